// File: doc/BRIEF.md
# Serial ADC Control Front-End

This block is the digital side of a 10-bit successive-approximation converter that has eight analog inputs and three internal test levels. A fast system clock oversamples the serial pins: chip select, serial clock, frame sync, serial data in, clock polarity select and an asynchronous conversion-start pin. In each serial frame the block takes a 4-bit command, shifts out the previous 10-bit result, opens and closes the sampling window, starts the converter core and drops the end-of-conversion flag until the new result is ready.

The frame-sync level present when chip select falls picks one of two framings: microprocessor framing or DSP framing. That choice, together with the clock polarity select pin, decides which serial clock edge captures command bits, which edge shifts data out, and which edges bound the sampling window. A host can also run a conversion without a frame: it pulls the conversion-start pin low for as long as it wants to sample, then releases it. The converter core here is a behavioural stub that gives a fixed value for each channel after a set number of system clocks.

Top module: `adc_serial_ctrl`

## Requirements
- R1: When chip select falls, the synchronized frame-sync level is latched as the framing mode for that frame: 1 selects microprocessor framing and 0 selects DSP framing.
- R2: The command is taken MSB first on the first four capture edges of the frame. In microprocessor framing the capture edge is the rising serial clock edge when clock-polarity is 1 and the falling edge when it is 0. In DSP framing the rule is reversed. Data-in is ignored after the fourth capture.
- R3: Command codes 0..7 select analog channels and codes 8..10 select the test levels. Each of these sets `chan_sel_o` to the code and clears `pwr_down_o`. Code 11 clears `rate_fast_o`, code 12 sets it, code 13 sets `pwr_down_o`, and codes 14 and 15 change nothing.
- R4: The MSB of the previous result appears on `dout_o` when chip select falls. Each following bit appears after one shift edge: the falling edge in microprocessor framing and the rising edge in DSP framing, whatever the clock polarity.
- R5: `sample_en_o` rises at the fourth falling edge (microprocessor framing) or the fourth rising edge (DSP framing). It falls at the conversion start, or when chip select rises before the tenth closing edge.
- R6: The tenth rising edge (microprocessor framing) or the tenth falling edge (DSP framing) gives a one-cycle `conv_start_o` pulse and drives `eoc_o` low. `eoc_o` stays low until the core delivers the result. A frame with fewer than ten clocks starts no conversion.
- R7: From the tenth falling serial clock edge onward, `dout_o` is 0, so frames of up to 16 clocks shift zeros after the ten result bits.
- R8: While chip select is high, `dout_oe_o` is 0 and serial clock and data-in edges have no effect.
- R9: A chip-select fall during a conversion aborts it. `eoc_o` returns high and the result register keeps its previous value.
- R10: With chip select high and the block idle, a fall of the conversion-start pin raises `sample_en_o`. Its rise starts a conversion of the selected channel, with `eoc_o` low until the result is ready.
- R11: The result is `{c[2:0], ~c[2:0], 4'b0101}` for channel c in 0..7. It is 0x200 for code 8, 0x000 for code 9 and 0x3FF for code 10. It is written only when a conversion completes, `CONV_CLKS` system clocks after the start.
- R12: After reset, `dout_oe_o`=0, `eoc_o`=1, `sample_en_o`=0, `chan_sel_o`=0, `pwr_down_o`=0, `rate_fast_o`=1, and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| fs_i | input | 1 | Frame sync level (framing choice) |
| din_i | input | 1 | Serial command data |
| clkinv_i | input | 1 | Serial clock polarity select |
| xstart_n_i | input | 1 | Asynchronous sampling/conversion start, active low |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for the data-out pad driver |
| eoc_o | output | 1 | End of conversion, low while busy |
| sample_en_o | output | 1 | Sampling window toward the analog switch |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| chan_sel_o | output | 4 | Selected input code (0..10) |
| pwr_down_o | output | 1 | Power-down control |
| rate_fast_o | output | 1 | Conversion-rate control |

## Verification
Two functions share one serial clock edge. In DSP framing, the tenth falling edge both starts the conversion and forces data-out to zero. In microprocessor framing, the fourth falling edge both opens the sampling window and shifts out a result bit. Both cases come up naturally in DSP and microprocessor frames of 10 to 16 clocks. After each such edge the scoreboard expects both effects together: the expected data bit or zero, and the sampling or end-of-conversion level.

// File: rtl/adc_fe_pkg.sv
// Package: shared sizes and types for the serial ADC control front-end.
// Assumes a 10-bit result, a 4-bit command and eight analog inputs.
package adc_fe_pkg;
    localparam int RESULT_W   = 10;
    localparam int COMMAND_W  = 4;
    localparam int N_ANALOG   = 8;
    localparam int N_PINS     = 6;

    // framing chosen by the frame-sync level at the chip-select fall
    typedef enum logic {
        MODE_DSP = 1'b0,
        MODE_MPU = 1'b1
    } frame_mode_e;

    // conversion controller state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FSAMP = 2'd1,
        ST_XSAMP = 2'd2,
        ST_BUSY  = 2'd3
    } conv_st_e;

    // pin positions inside the synchronized pin vector
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_FS  = 2;
    localparam int PIN_DIN = 3;
    localparam int PIN_INV = 4;
    localparam int PIN_XST = 5;
endpackage

// File: rtl/adc_pin_sync.sv
// Module: two-flop synchronizer and edge detector for a vector of pins.
// Assumes each pin stays stable for at least two system clocks between changes.
module adc_pin_sync #(
    parameter int          W       = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1_q, s2_q, s3_q;

        // Two metastability stages plus one history stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[b];
                s2_q <= RST_VAL[b];
                s3_q <= RST_VAL[b];
            end else begin
                s1_q <= pin_i[b];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign lvl_o[b]  = s2_q;
        assign rise_o[b] = s2_q & ~s3_q;
        assign fall_o[b] = ~s2_q & s3_q;
    end
endmodule

// File: rtl/adc_frame_seq.sv
// Module: serial frame sequencer. It latches the framing mode, captures the
// command, shifts the previous result out and marks the sampling edges.
// Assumes synchronized single-cycle edge strobes from adc_pin_sync.
module adc_frame_seq
    import adc_fe_pkg::*;
#(
    parameter int RES_W    = RESULT_W,
    parameter int CMD_W    = COMMAND_W,
    parameter int MAX_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             fs_lvl,
    input  logic             din_lvl,
    input  logic             inv_lvl,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_word,
    output logic             open_f,
    output logic             close_f
);
    localparam int CNT_W = $clog2(MAX_CLKS + 1);
    localparam int CC_W  = $clog2(CMD_W + 1);
    localparam logic [CNT_W-1:0] OPEN_IDX  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] CLOSE_IDX = CNT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_CLKS);
    localparam logic [CC_W-1:0]  CC_LAST   = CC_W'(CMD_W - 1);
    localparam logic [CC_W-1:0]  CC_FULL   = CC_W'(CMD_W);

    logic             active_q;
    frame_mode_e      mode_q;
    logic [CNT_W-1:0] rise_cnt_q, fall_cnt_q;
    logic [CC_W-1:0]  cc_q;
    logic [CMD_W-2:0] cmd_sh_q;
    logic [RES_W-1:0] out_sh_q;
    logic             zero_q;

    logic             live_r, live_f, is_mpu, cap, take, shift, zero_hit;
    logic [CMD_W-1:0] cmd_nxt;

    // Decode which strobes count in this frame for the latched mode and polarity.
    always_comb begin
        live_r   = active_q & sclk_rise & ~cs_fall;
        live_f   = active_q & sclk_fall & ~cs_fall;
        is_mpu   = (mode_q == MODE_MPU);
        if (is_mpu) cap = inv_lvl ? live_r : live_f;
        else        cap = inv_lvl ? live_f : live_r;
        take     = cap && (cc_q < CC_FULL);
        shift    = is_mpu ? live_f : live_r;
        open_f   = is_mpu ? (live_f && fall_cnt_q == OPEN_IDX)
                          : (live_r && rise_cnt_q == OPEN_IDX);
        close_f  = is_mpu ? (live_r && rise_cnt_q == CLOSE_IDX)
                          : (live_f && fall_cnt_q == CLOSE_IDX);
        zero_hit = live_f && (fall_cnt_q == CLOSE_IDX);
        cmd_nxt  = {cmd_sh_q, din_lvl};
    end

    assign cmd_valid = take && (cc_q == CC_LAST);
    assign cmd_word  = cmd_nxt;
    assign dout      = out_sh_q[RES_W-1] & ~zero_q;
    assign dout_oe   = active_q;

    // Frame activity and framing mode, set at the chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            mode_q   <= MODE_MPU;
        end else if (cs_fall) begin
            active_q <= 1'b1;
            mode_q   <= fs_lvl ? MODE_MPU : MODE_DSP;
        end else if (cs_rise) begin
            active_q <= 1'b0;
        end
    end

    // Saturating counts of the rising and falling serial edges in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            rise_cnt_q <= '0;
            fall_cnt_q <= '0;
        end else begin
            if (live_r && rise_cnt_q != CNT_MAX) rise_cnt_q <= rise_cnt_q + 1'b1;
            if (live_f && fall_cnt_q != CNT_MAX) fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end

    // Command shift register, filled MSB first on the first capture edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            cc_q     <= '0;
            cmd_sh_q <= '0;
        end else if (take) begin
            cc_q     <= cc_q + 1'b1;
            cmd_sh_q <= cmd_nxt[CMD_W-2:0];
        end
    end

    // Result shifter: loaded at the frame start, moves one bit per shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sh_q <= '0;
            zero_q   <= 1'b0;
        end else if (cs_fall) begin
            out_sh_q <= result;
            zero_q   <= 1'b0;
        end else begin
            if (shift)    out_sh_q <= {out_sh_q[RES_W-2:0], 1'b0};
            if (zero_hit) zero_q   <= 1'b1;
        end
    end

    AST_CMD_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cc_q <= CC_FULL);  // R2
    AST_OE_DROPS_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !dout_oe);  // R8
    AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !open_f && !close_f && !cmd_valid);  // R8
endmodule

// File: rtl/adc_conv_ctrl.sv
// Module: sampling and conversion controller. It opens and closes the sampling
// window from frame or start-pin events, starts the core, drives end-of-conversion
// and handles aborts.
// Assumes single-cycle event strobes.
module adc_conv_ctrl
    import adc_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_f,
    input  logic close_f,
    input  logic abort,
    input  logic frame_end,
    input  logic cs_idle,
    input  logic xs_fall,
    input  logic xs_rise,
    input  logic core_done,
    output logic sample_en,
    output logic conv_start,
    output logic eoc
);
    conv_st_e st_q, st_d;
    logic     go;

    // Next-state decode. An abort wins over every other event.
    always_comb begin
        st_d = st_q;
        go   = 1'b0;
        if (abort) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (open_f)                st_d = ST_FSAMP;
                    else if (xs_fall && cs_idle) st_d = ST_XSAMP;
                end
                ST_FSAMP: begin
                    if (close_f) begin
                        st_d = ST_BUSY;
                        go   = 1'b1;
                    end else if (frame_end) begin
                        st_d = ST_IDLE;
                    end
                end
                ST_XSAMP: begin
                    if (xs_rise) begin
                        st_d = ST_BUSY;
                        go   = 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (core_done) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State and start-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            conv_start <= 1'b0;
        end else begin
            st_q       <= st_d;
            conv_start <= go;
        end
    end

    assign sample_en = (st_q == ST_FSAMP) || (st_q == ST_XSAMP);
    assign eoc       = (st_q != ST_BUSY);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);  // R6
    AST_EOC_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !eoc);  // R6
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> eoc && !sample_en);  // R9
    AST_NO_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |-> !sample_en);  // R5
endmodule

// File: rtl/adc_core_stub.sv
// Module: behavioural converter core. It returns a fixed code per input
// CONV_CLKS system clocks after a start.
// Assumes no start arrives while a conversion is running.
module adc_core_stub
    import adc_fe_pkg::*;
#(
    parameter int RES_W     = RESULT_W,
    parameter int SEL_W     = COMMAND_W,
    parameter int CONV_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [SEL_W-1:0] ch,
    output logic             done,
    output logic [RES_W-1:0] value
);
    localparam int CW = $clog2(CONV_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_CLKS - 1);

    logic             busy_q;
    logic [CW-1:0]    cnt_q;
    logic [SEL_W-1:0] ch_q;

    assign done = busy_q && (cnt_q == LAST) && !abort;

    // Conversion timer with channel latch; an abort cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            ch_q   <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            ch_q   <= ch;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Deterministic code for each analog channel and test level.
    always_comb begin
        if (ch_q < SEL_W'(N_ANALOG))
            value = RES_W'({ch_q[2:0], ~ch_q[2:0], 4'b0101});
        else if (ch_q == SEL_W'(N_ANALOG))
            value = RES_W'(1) << (RES_W - 1);
        else if (ch_q == SEL_W'(N_ANALOG + 1))
            value = '0;
        else
            value = '1;
    end

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);  // R6
endmodule

// File: rtl/adc_serial_ctrl.sv
// Module: top of the serial ADC control front-end. It synchronizes the pins,
// runs the frame sequencer and conversion controller, decodes commands and
// holds the result.
// Assumes clk is at least 8x the serial clock rate.
module adc_serial_ctrl
    import adc_fe_pkg::*;
#(
    parameter int RES_W     = RESULT_W,
    parameter int CMD_W     = COMMAND_W,
    parameter int MAX_CLKS  = 16,
    parameter int CONV_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             fs_i,
    input  logic             din_i,
    input  logic             clkinv_i,
    input  logic             xstart_n_i,
    output logic             dout_o,
    output logic             dout_oe_o,
    output logic             eoc_o,
    output logic             sample_en_o,
    output logic             conv_start_o,
    output logic [CMD_W-1:0] chan_sel_o,
    output logic             pwr_down_o,
    output logic             rate_fast_o
);
    localparam logic [CMD_W-1:0] LAST_SEL  = CMD_W'(N_ANALOG + 2);
    localparam logic [CMD_W-1:0] CODE_SLOW = CMD_W'(N_ANALOG + 3);
    localparam logic [CMD_W-1:0] CODE_FAST = CMD_W'(N_ANALOG + 4);
    localparam logic [CMD_W-1:0] CODE_PD   = CMD_W'(N_ANALOG + 5);
    localparam logic [N_PINS-1:0] PIN_RST  = N_PINS'(6'b110101);

    logic [N_PINS-1:0] pins, lvl, rise, fall;
    logic              cmd_valid, open_f, close_f, core_done;
    logic [CMD_W-1:0]  cmd_word;
    logic [RES_W-1:0]  core_value, result_q;

    always_comb begin
        pins          = '0;
        pins[PIN_CS]  = cs_n_i;
        pins[PIN_SCK] = sclk_i;
        pins[PIN_FS]  = fs_i;
        pins[PIN_DIN] = din_i;
        pins[PIN_INV] = clkinv_i;
        pins[PIN_XST] = xstart_n_i;
    end

    adc_pin_sync #(.W(N_PINS), .RST_VAL(PIN_RST)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pins),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    adc_frame_seq #(.RES_W(RES_W), .CMD_W(CMD_W), .MAX_CLKS(MAX_CLKS)) frame_i (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(fall[PIN_CS]), .cs_rise(rise[PIN_CS]),
        .sclk_rise(rise[PIN_SCK]), .sclk_fall(fall[PIN_SCK]),
        .fs_lvl(lvl[PIN_FS]), .din_lvl(lvl[PIN_DIN]), .inv_lvl(lvl[PIN_INV]),
        .result(result_q), .dout(dout_o), .dout_oe(dout_oe_o),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .open_f(open_f), .close_f(close_f)
    );

    adc_conv_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .open_f(open_f), .close_f(close_f),
        .abort(fall[PIN_CS]), .frame_end(rise[PIN_CS]), .cs_idle(lvl[PIN_CS]),
        .xs_fall(fall[PIN_XST]), .xs_rise(rise[PIN_XST]),
        .core_done(core_done), .sample_en(sample_en_o),
        .conv_start(conv_start_o), .eoc(eoc_o)
    );

    adc_core_stub #(.RES_W(RES_W), .SEL_W(CMD_W), .CONV_CLKS(CONV_CLKS)) core_i (
        .clk(clk), .rst_n(rst_n), .start(conv_start_o), .abort(fall[PIN_CS]),
        .ch(chan_sel_o), .done(core_done), .value(core_value)
    );

    // Command decode: select input, or set the rate and power controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel_o  <= '0;
            pwr_down_o  <= 1'b0;
            rate_fast_o <= 1'b1;
        end else if (cmd_valid) begin
            if (cmd_word <= LAST_SEL) begin
                chan_sel_o <= cmd_word;
                pwr_down_o <= 1'b0;
            end else if (cmd_word == CODE_SLOW) begin
                rate_fast_o <= 1'b0;
            end else if (cmd_word == CODE_FAST) begin
                rate_fast_o <= 1'b1;
            end else if (cmd_word == CODE_PD) begin
                pwr_down_o <= 1'b1;
            end
        end
    end

    // Result register, written only when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         result_q <= '0;
        else if (core_done) result_q <= core_value;
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(result_q));  // R11
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel_o <= LAST_SEL);  // R3
endmodule

// File: tb/adc_serial_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares them.
module adc_serial_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int CONV       = 64;

    localparam int K_DOUT = 0, K_OE = 1, K_EOC = 2, K_SEL = 3,
                   K_SAMP = 4, K_PWR = 5, K_RATE = 6;

    typedef struct {
        int         kind;
        logic [9:0] exp;
        string      req;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, fs = 1'b1, din = 1'b0, inv = 1'b1, xs_n = 1'b1;
    logic dout, dout_oe, eoc, samp, cstart, pwr, rate;
    logic [3:0] sel;

    item_t q[$];
    event  push_ev;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;

    logic [9:0] last_res = '0;
    int         cur_sel = 0;
    bit         cur_pwr = 0, cur_rate = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_ctrl #(.CONV_CLKS(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .fs_i(fs),
        .din_i(din), .clkinv_i(inv), .xstart_n_i(xs_n),
        .dout_o(dout), .dout_oe_o(dout_oe), .eoc_o(eoc), .sample_en_o(samp),
        .conv_start_o(cstart), .chan_sel_o(sel), .pwr_down_o(pwr), .rate_fast_o(rate)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [9:0] v, input string req);
        item_t it;
        it.kind = kind; it.exp = v; it.req = req;
        q.push_back(it);
        -> push_ev;
    endtask

    function automatic logic [9:0] model(input int ch);
        logic [3:0] c = 4'(ch);
        if (ch < 8)       return {c[2:0], ~c[2:0], 4'b0101};
        else if (ch == 8) return 10'h200;
        else if (ch == 9) return 10'h000;
        else              return 10'h3FF;
    endfunction

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(push_ev);
            while (q.size() != 0) begin
                item_t it;
                logic [9:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_DOUT:  act = {9'b0, dout};
                    K_OE:    act = {9'b0, dout_oe};
                    K_EOC:   act = {9'b0, eoc};
                    K_SEL:   act = {6'b0, sel};
                    K_SAMP:  act = {9'b0, samp};
                    K_PWR:   act = {9'b0, pwr};
                    default: act = {9'b0, rate};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h at %0t",
                             it.req, it.kind, act, it.exp, $time);
                end
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One serial frame: mode, clock polarity, command, clock count, wait for completion.
    task automatic run_frame(input bit mpu, input bit pol, input logic [3:0] cmd,
                             input int nclk, input bit let_finish);
        fs = mpu; inv = pol;
        tick(2);
        cs_n = 1'b0;
        tick(H);
        expect_item(K_OE, 10'd1, "R8");
        expect_item(K_EOC, 10'd1, "R9");
        expect_item(K_DOUT, {9'b0, last_res[9]}, "R4");
        if (cmd <= 4'd10) begin
            cur_sel = int'(cmd); cur_pwr = 0;
        end else if (cmd == 4'd11) cur_rate = 0;
        else if (cmd == 4'd12) cur_rate = 1;
        else if (cmd == 4'd13) cur_pwr = 1;
        for (int i = 1; i <= nclk; i++) begin
            din = (i <= 4) ? cmd[4-i] : ~cmd[i%4];
            tick(H);
            sclk = 1'b1;
            tick(H);
            if (!mpu) expect_item(K_DOUT, (i < 10) ? {9'b0, last_res[9-i]} : 10'd0,
                                  (i < 10) ? "R4" : "R7");
            sclk = 1'b0;
            tick(H);
            if (mpu) expect_item(K_DOUT, (i < 10) ? {9'b0, last_res[9-i]} : 10'd0,
                                 (i < 10) ? "R4" : "R7");
            if (i == 5) begin
                expect_item(K_SAMP, 10'd1, "R5");
                expect_item(K_SEL, 10'(cur_sel), "R2");
                expect_item(K_PWR, {9'b0, cur_pwr}, "R3");
                expect_item(K_RATE, {9'b0, cur_rate}, "R3");
            end
            if (i == 10) begin
                expect_item(K_SAMP, 10'd0, "R5");
                expect_item(K_EOC, 10'd0, "R6");
            end
        end
        cs_n = 1'b1;
        tick(H);
        expect_item(K_OE, 10'd0, "R8");
        if (nclk < 10) begin
            expect_item(K_SAMP, 10'd0, "R5");
            expect_item(K_EOC, 10'd1, "R6");
        end
        // serial edges with chip select high must not change anything (R8)
        for (int k = 0; k < 3; k++) begin
            sclk = ~sclk; din = ~din;
            tick(2);
        end
        sclk = 1'b0;
        tick(2);
        expect_item(K_SEL, 10'(cur_sel), "R8");
        if (let_finish && nclk >= 10) begin
            tick(CONV + 16);
            expect_item(K_EOC, 10'd1, "R6");
            last_res = model(cur_sel);
        end
    endtask

    // Conversion started from the asynchronous start pin with chip select high.
    task automatic ext_conv;
        xs_n = 1'b0;
        tick(H);
        expect_item(K_SAMP, 10'd1, "R10");
        expect_item(K_EOC, 10'd1, "R10");
        tick(20);
        xs_n = 1'b1;
        tick(H);
        expect_item(K_EOC, 10'd0, "R10");
        expect_item(K_SAMP, 10'd0, "R10");
        tick(CONV + 16);
        expect_item(K_EOC, 10'd1, "R10");
        last_res = model(cur_sel);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(3);
        // R12 reset state
        expect_item(K_OE, 10'd0, "R12");
        expect_item(K_EOC, 10'd1, "R12");
        expect_item(K_SAMP, 10'd0, "R12");
        expect_item(K_SEL, 10'd0, "R12");
        expect_item(K_PWR, 10'd0, "R12");
        expect_item(K_RATE, 10'd1, "R12");
        // R1 microprocessor framing, rising capture; R11 channel 3
        run_frame(1'b1, 1'b1, 4'd3, 10, 1'b1);
        // R1 DSP framing, rising capture, 16 clocks of which 6 are zeros (R7)
        run_frame(1'b0, 1'b0, 4'd9, 16, 1'b1);
        // microprocessor framing, falling capture; test level 8
        run_frame(1'b1, 1'b0, 4'd8, 12, 1'b1);
        // DSP framing, falling capture; conversion aborted by the next frame (R9)
        run_frame(1'b0, 1'b1, 4'd5, 10, 1'b0);
        // R3 power-down; old result still read out after the abort
        run_frame(1'b1, 1'b1, 4'd13, 10, 1'b1);
        run_frame(1'b1, 1'b1, 4'd11, 10, 1'b1);
        run_frame(1'b0, 1'b0, 4'd14, 11, 1'b1);
        run_frame(1'b1, 1'b1, 4'd12, 10, 1'b1);
        // short frame: channel 7 chosen, no conversion (R6)
        run_frame(1'b1, 1'b1, 4'd7, 6, 1'b0);
        // R10 start-pin conversion of channel 7
        ext_conv();
        run_frame(1'b0, 1'b1, 4'd10, 16, 1'b1);
        run_frame(1'b1, 1'b0, 4'd0, 10, 1'b1);
        run_frame(1'b1, 1'b1, 4'd1, 10, 1'b1);
        tick(5);
        finished = 1;
        summary();
        $finish;
    end
endmodule